// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a stream of bytes waiting in a transmit FIFO into a serial HDLC bit stream, one line bit for every clock cycle on which `bit_en` is high. It brackets each packet with flags, inserts a zero after any run of five ones inside the packet body, appends a 16-bit frame check sequence, and replaces a tagged byte with an abort pattern. Between packets it fills the line either with continuous ones or with continuous flags.

Each FIFO entry carries two tags. An end-of-packet tag marks the final byte of a packet. An abort tag marks a byte that must not go out: an abort pattern is sent in its place. The FIFO is show-ahead: the head entry stays on the inputs until the framer pulses `fifo_pop`. If the FIFO runs dry in the middle of a packet, the framer sends an abort and raises `underrun` while that abort is on the line.

The controller works in units: one idle one, an 8-bit flag, an 8-bit abort, an 8-bit data byte, or the 16-bit check sequence. States are `ST_MARK`, `ST_FLAG`, `ST_ABORT`, `ST_DATA` and `ST_FCS`. A new unit is picked only when the current one has finished, including any stuffed zero still owed.

The transitions are:
- From `ST_MARK` or `ST_ABORT`: to `ST_FLAG` if transmission is enabled and the FIFO holds data. Otherwise to `ST_MARK` when mark idle is selected, or to `ST_FLAG` when it is not.
- From `ST_FLAG`: if transmission is enabled and the FIFO holds data, the head byte is popped. The framer then goes to `ST_ABORT` if that byte carries the abort tag, and to `ST_DATA` if it does not. With nothing to send, the idle choice above applies.
- From `ST_DATA`:
  - after a byte with the end tag, to `ST_FCS`, or to `ST_FLAG` when CRC inhibit is set;
  - when the FIFO is empty, to `ST_ABORT` as an underrun;
  - otherwise the next byte is popped, and the framer goes to `ST_ABORT` or `ST_DATA` according to that byte's abort tag.
- From `ST_FCS`: always to `ST_FLAG`.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While reset is asserted, `tx_bit` is 1, `fifo_pop` is 0 and `underrun` is 0. After reset the line starts in the one-bit idle unit.
- R2: With nothing to send, or with `tx_enable` low, the line carries continuous ones when `mark_idle` is 1. When `mark_idle` is 0, it carries back-to-back flags, each flag being 0x7E sent LSB first (0,1,1,1,1,1,1,0).
- R3: Data that arrives while the line is in mark idle or in an abort is preceded by one full flag. Data that arrives during flag idle begins straight after the flag currently being sent.
- R4: Data bytes are sent LSB first. After every five consecutive ones in the data and check-sequence bits, a single 0 is inserted, and the run count carries across byte and check-sequence boundaries. Flags and aborts are never stuffed.
- R5: After the byte tagged end-of-packet, the 16-bit check sequence is sent, followed by a closing flag. The check sequence is computed bit-serially over the data bits in send order, with the reflected polynomial 0x8408 (x^16+x^12+x^5+1) and a preset of 0xFFFF. Its ones' complement is sent LSB first.
- R6: When the next packet is already queued at a closing flag, that flag also serves as the opening flag: exactly one flag separates the two packets.
- R7: A byte tagged abort is popped but never sent. The abort pattern 0x7F, sent LSB first (seven ones then a 0), goes out after all earlier bytes of the packet. Afterwards the idle choice of R2 and R3 applies.
- R8: When a data byte without the end tag finishes and the FIFO is empty, an abort is sent. `underrun` is high for exactly the cycles that abort occupies.
- R9: With `crc_inhibit` set, no check sequence is sent: the closing flag follows the end-tagged byte and its stuffed zero, if one is owed.
- R10: `tx_enable` is consulted only when a packet would start. Clearing it mid-packet lets the packet finish, and queued bytes stay in the FIFO untouched until it is set again.
- R11: `fifo_pop` is a one-cycle strobe that is raised only when the FIFO is not empty. It coincides with the `bit_en` cycle on which a new unit begins.
- R12: The line bit and all framer state advance only on cycles with `bit_en` high. On other cycles `tx_bit` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Line bit strobe; one bit is sent per high cycle |
| tx_enable | input | 1 | Permits new packets to start |
| mark_idle | input | 1 | Idle fill select: 1 = all ones, 0 = flags |
| crc_inhibit | input | 1 | Suppresses the check sequence |
| fifo_data | input | DATA_W | Head byte of the transmit FIFO |
| fifo_eop | input | 1 | Head byte is the last of its packet |
| fifo_abort | input | 1 | Head byte is to be replaced by an abort |
| fifo_empty | input | 1 | FIFO holds no entries |
| fifo_pop | output | 1 | Removes the head entry at this clock edge |
| tx_bit | output | 1 | Serial line bit |
| underrun | output | 1 | High while an underrun-triggered abort is sent |

## Verification
The assertions take for granted that the FIFO model behaves like a show-ahead FIFO. Its head entry and its empty flag change only as a result of a pop or of a write while it is empty, so an underrun observed one cycle later can be traced back to an empty FIFO at the decision edge. The bench meets this condition by changing the FIFO pins and all control inputs only at the falling edge, and by applying a pop one cycle after the strobe that requested it. The bench also compares every line bit against a bit queue that it builds independently for each unit. It does so under steady and gapped `bit_en` patterns, so that stalls are exercised in every state.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    typedef enum logic [2:0] {
        ST_MARK,
        ST_FLAG,
        ST_ABORT,
        ST_DATA,
        ST_FCS
    } unit_e;

    localparam logic [7:0]  FLAG_PAT     = 8'h7E;
    localparam logic [7:0]  ABORT_PAT    = 8'h7F;
    localparam int          PAT_LEN      = 8;
    localparam logic [15:0] CRC_SEED     = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REV = 16'h8408;
endpackage

// File: rtl/hdlc_crc16.sv
module hdlc_crc16 #(
    parameter int          CRC_W = 16,
    parameter logic [15:0] POLY  = 16'h8408,
    parameter logic [15:0] SEED  = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             upd,
    input  logic             din,
    output logic [CRC_W-1:0] crc_next
);
    logic [CRC_W-1:0] crc_q;
    logic             fb;

    always_comb begin
        fb = crc_q[0] ^ din;
        if (init)
            crc_next = SEED[CRC_W-1:0];
        else if (upd)
            crc_next = (crc_q >> 1) ^ (fb ? POLY[CRC_W-1:0] : '0);
        else
            crc_next = crc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= SEED[CRC_W-1:0];
        else        crc_q <= crc_next;
    end
endmodule

// File: rtl/hdlc_zero_stuff.sv
module hdlc_zero_stuff #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic active,
    input  logic bit_in,
    output logic stuff_now,
    output logic will_stuff
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    logic [CNT_W-1:0] ones_q;

    always_comb begin
        stuff_now  = active && (ones_q == CNT_W'(RUN_LEN));
        will_stuff = active && !stuff_now && bit_in && (ones_q == CNT_W'(RUN_LEN - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ones_q <= '0;
        else if (advance) begin
            if (!active || stuff_now) ones_q <= '0;
            else if (bit_in)          ones_q <= ones_q + 1'b1;
            else                      ones_q <= '0;
        end
    end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CRC_W   = 16,
    parameter int RUN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              tx_enable,
    input  logic              mark_idle,
    input  logic              crc_inhibit,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_eop,
    input  logic              fifo_abort,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    output logic              tx_bit,
    output logic              underrun
);
    localparam int                LEFT_W  = $clog2(CRC_W + 1);
    localparam int                PAD_W   = CRC_W - DATA_W;
    localparam int                PPAD_W  = CRC_W - PAT_LEN;
    localparam logic [LEFT_W-1:0] ONE     = LEFT_W'(1);
    localparam logic [LEFT_W-1:0] BYTE_N  = LEFT_W'(DATA_W);
    localparam logic [LEFT_W-1:0] PAT_N   = LEFT_W'(PAT_LEN);
    localparam logic [LEFT_W-1:0] FCS_N   = LEFT_W'(CRC_W);

    unit_e             state_q, state_d;
    logic [CRC_W-1:0]  shreg_q, load_d, crc_next;
    logic [LEFT_W-1:0] left_q, len_d;
    logic              eop_q, uf_q;
    logic              take, set_uf, crc_init;
    logic              stuffed, stuff_now, will_stuff, unit_end;

    hdlc_zero_stuff #(.RUN_LEN(RUN_LEN)) u_stuff (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (bit_en),
        .active     (stuffed),
        .bit_in     (shreg_q[0]),
        .stuff_now  (stuff_now),
        .will_stuff (will_stuff)
    );

    hdlc_crc16 #(.CRC_W(CRC_W), .POLY(CRC_POLY_REV), .SEED(CRC_SEED)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (bit_en && unit_end && crc_init),
        .upd      (bit_en && !stuff_now && (state_q == ST_DATA)),
        .din      (shreg_q[0]),
        .crc_next (crc_next)
    );

    // Next unit choice, evaluated every cycle, taken when the unit ends
    always_comb begin
        state_d  = state_q;
        take     = 1'b0;
        set_uf   = 1'b0;
        crc_init = 1'b0;
        unique case (state_q)
            ST_MARK, ST_FLAG, ST_ABORT: begin
                if (tx_enable && !fifo_empty) begin
                    if (state_q == ST_FLAG) begin
                        take = 1'b1;
                        if (fifo_abort) state_d = ST_ABORT;
                        else begin
                            state_d  = ST_DATA;
                            crc_init = 1'b1;
                        end
                    end else
                        state_d = ST_FLAG;
                end else
                    state_d = mark_idle ? ST_MARK : ST_FLAG;
            end
            ST_DATA: begin
                if (eop_q)
                    state_d = crc_inhibit ? ST_FLAG : ST_FCS;
                else if (fifo_empty) begin
                    state_d = ST_ABORT;
                    set_uf  = 1'b1;
                end else begin
                    take    = 1'b1;
                    state_d = fifo_abort ? ST_ABORT : ST_DATA;
                end
            end
            ST_FCS:  state_d = ST_FLAG;
            default: state_d = ST_MARK;
        endcase
    end

    // Shift register contents for the chosen unit
    always_comb begin
        unique case (state_d)
            ST_FLAG:  begin load_d = {{PPAD_W{1'b1}}, FLAG_PAT};  len_d = PAT_N;  end
            ST_ABORT: begin load_d = {{PPAD_W{1'b1}}, ABORT_PAT}; len_d = PAT_N;  end
            ST_DATA:  begin load_d = {{PAD_W{1'b1}}, fifo_data};  len_d = BYTE_N; end
            ST_FCS:   begin load_d = ~crc_next;                   len_d = FCS_N;  end
            default:  begin load_d = '1;                          len_d = ONE;    end
        endcase
    end

    // Outputs
    always_comb begin
        stuffed  = (state_q == ST_DATA) || (state_q == ST_FCS);
        unit_end = stuff_now ? (left_q == '0) : ((left_q == ONE) && !will_stuff);
        tx_bit   = stuff_now ? 1'b0 : shreg_q[0];
        fifo_pop = bit_en && unit_end && take;
        underrun = uf_q;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MARK;
            shreg_q <= '1;
            left_q  <= ONE;
            eop_q   <= 1'b0;
            uf_q    <= 1'b0;
        end else if (bit_en) begin
            if (unit_end) begin
                state_q <= state_d;
                shreg_q <= load_d;
                left_q  <= len_d;
                eop_q   <= (state_d == ST_DATA) && fifo_eop;
                uf_q    <= set_uf;
            end else if (!stuff_now) begin
                shreg_q <= shreg_q >> 1;
                left_q  <= left_q - ONE;
            end
        end
    end
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic fifo_empty,
    input logic fifo_abort,
    input logic fifo_pop,
    input logic tx_bit,
    input logic underrun
);
    // R11
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R11
    pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    // R12
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));

    // R8
    underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(fifo_empty));

    // R8
    underrun_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !fifo_pop);

    // R7
    abort_starts_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && fifo_abort) |=> tx_bit);
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .fifo_empty (fifo_empty),
    .fifo_abort (fifo_abort),
    .fifo_pop   (fifo_pop),
    .tx_bit     (tx_bit),
    .underrun   (underrun)
);

// File: tb/hdlc_tx_framer_bench.sv
module hdlc_tx_framer_bench;
    localparam int K_MARK = 0, K_FLAG = 1, K_ABORT = 2, K_DATA = 3, K_FCS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, tx_enable = 1'b0, mark_idle = 1'b1, crc_inhibit = 1'b0;
    logic [7:0] fifo_data = '0;
    logic       fifo_eop = 1'b0, fifo_abort = 1'b0, fifo_empty = 1'b1;
    logic       fifo_pop, tx_bit, underrun;

    hdlc_tx_framer u_hdlc_tx_framer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_enable(tx_enable),
        .mark_idle(mark_idle), .crc_inhibit(crc_inhibit), .fifo_data(fifo_data),
        .fifo_eop(fifo_eop), .fifo_abort(fifo_abort), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop), .tx_bit(tx_bit), .underrun(underrun)
    );

    always #5 clk = ~clk;

    // FIFO entries: {abort, eop, data}
    logic [9:0] fq[$];
    logic       exp_q[$];
    int         kind = K_MARK, ones = 0, en_mod = 0, cyc = 0, checks = 0, fails = 0;
    logic [15:0] crc = 16'hFFFF;
    logic       cur_eop = 0, exp_uf = 0, exp_pop = 0, pend_pop = 0;
    logic       c_en = 0, c_mark = 1, c_inh = 0;
    string      scen = "reset";

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] cycle %0d: actual=%0d expected=%0d", tag, scen, cyc, act, exp);
        end
    endtask

    task automatic push_stuffed(input logic b);
        exp_q.push_back(b);
        ones = b ? ones + 1 : 0;
        if (ones == 5) begin exp_q.push_back(1'b0); ones = 0; end
    endtask

    task automatic put_flag();
        kind = K_FLAG; ones = 0; exp_uf = 0;
        exp_q.push_back(0);
        for (int i = 0; i < 6; i++) exp_q.push_back(1);
        exp_q.push_back(0);
    endtask

    task automatic put_abort(input logic uf);
        kind = K_ABORT; ones = 0; exp_uf = uf;
        for (int i = 0; i < 7; i++) exp_q.push_back(1);
        exp_q.push_back(0);
    endtask

    task automatic put_mark();
        kind = K_MARK; ones = 0; exp_uf = 0;
        exp_q.push_back(1);
    endtask

    task automatic put_data(input logic [9:0] e);
        kind = K_DATA; exp_uf = 0; cur_eop = e[8];
        for (int i = 0; i < 8; i++) begin
            crc = (crc >> 1) ^ ((crc[0] ^ e[i]) ? 16'h8408 : 16'h0000);
            push_stuffed(e[i]);
        end
    endtask

    task automatic put_fcs();
        logic [15:0] f;
        f = ~crc;
        kind = K_FCS; exp_uf = 0;
        for (int i = 0; i < 16; i++) push_stuffed(f[i]);
    endtask

    task automatic fill();
        bit have;
        have = tx_enable && (fq.size() > 0);
        if (kind == K_DATA) begin
            if (cur_eop) begin
                if (crc_inhibit) put_flag(); else put_fcs();
            end else if (fq.size() == 0) put_abort(1);
            else begin
                exp_pop = 1;
                if (fq[0][9]) put_abort(0); else put_data(fq[0]);
            end
        end else if (kind == K_FCS) put_flag();
        else if (have && kind == K_FLAG) begin
            exp_pop = 1;
            if (fq[0][9]) put_abort(0);
            else begin crc = 16'hFFFF; put_data(fq[0]); end
        end else if (have) put_flag();
        else if (mark_idle) put_mark();
        else put_flag();
    endtask

    function automatic string kind_tag(input int k);
        case (k)
            K_MARK:  return "R2";
            K_FLAG:  return "R3";
            K_ABORT: return "R7";
            K_DATA:  return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
        if (pend_pop && fq.size() > 0) void'(fq.pop_front());
        pend_pop    = 0;
        tx_enable   = c_en;
        mark_idle   = c_mark;
        crc_inhibit = c_inh;
        bit_en      = rst_n && ((en_mod == 0) || (cyc % en_mod != 0));
        fifo_empty  = (fq.size() == 0);
        fifo_data   = fifo_empty ? 8'h00 : fq[0][7:0];
        fifo_eop    = fifo_empty ? 1'b0 : fq[0][8];
        fifo_abort  = fifo_empty ? 1'b0 : fq[0][9];
        #1;
        cyc++;
        if (rst_n) begin
            chk(tx_bit === exp_q[0], bit_en ? kind_tag(kind) : "R12", tx_bit, exp_q[0]);
            chk(underrun === exp_uf, "R8", underrun, exp_uf);
            exp_pop = 0;
            if (bit_en) begin
                void'(exp_q.pop_front());
                if (exp_q.size() == 0) fill();
            end
            chk(fifo_pop === exp_pop, "R11", fifo_pop, exp_pop);
            pend_pop = exp_pop;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic push(input logic [7:0] d, input logic eop, input logic fa);
        fq.push_back({fa, eop, d});
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        exp_q.push_back(1);
        c_en = 1; c_mark = 1;
        push(8'h55, 1, 0);
        run(3);
        chk(tx_bit === 1'b1, "R1", tx_bit, 1);
        chk(fifo_pop === 1'b0, "R1", fifo_pop, 0);
        chk(underrun === 1'b0, "R1", underrun, 0);
        fq.delete();
        rst_n = 1;

        scen = "R2 mark idle";      run(20);
        scen = "R3 R5 from mark";   push(8'hAA, 0, 0); push(8'h03, 0, 0); push(8'h77, 1, 0); run(120);
        scen = "R2 flag idle";      c_mark = 0; run(40);
        scen = "R3 from flag idle"; push(8'h5A, 1, 0); run(80);
        scen = "R6 R4 back to back";
        push(8'hFF, 0, 0); push(8'hFF, 0, 0); push(8'h3E, 1, 0);
        push(8'h12, 0, 0); push(8'h34, 1, 0); run(200);
        scen = "R7 tagged abort";   c_mark = 1; push(8'h55, 0, 0); push(8'h66, 0, 1); run(80);
        scen = "R8 underrun";       push(8'h11, 0, 0); push(8'h22, 0, 0); run(100);
        scen = "R9 crc inhibit";    c_inh = 1; push(8'hF8, 0, 0); push(8'h1F, 1, 0); run(80);
        c_inh = 0;
        scen = "R12 gapped strobe"; en_mod = 3; c_mark = 0;
        push(8'hC3, 0, 0); push(8'hFE, 1, 0); push(8'h99, 0, 1); run(200);
        en_mod = 0; c_mark = 1;
        scen = "R10 disable mid packet";
        push(8'h01, 0, 0); push(8'h02, 0, 0); push(8'h03, 1, 0);
        push(8'hA5, 0, 0); push(8'h5A, 1, 0);
        run(12);
        c_en = 0;
        run(300);
        chk(fq.size() == 2, "R10", fq.size(), 2);
        c_en = 1;
        run(150);
        chk(fq.size() == 0, "R10", fq.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule